// File: doc/BRIEF.md
# NaN Classifier and Quieter for Half, Single and Double Precision

This combinational unit inspects one floating-point word and reports whether it holds a quiet NaN or a signaling NaN. It also returns a quieted copy of the word and the canonical default NaN for the selected format. Three binary interchange formats are covered: half precision with a 5-bit exponent and 10-bit fraction, single precision with 8 and 23 bits, and double precision with 11 and 52 bits. All three keep the sign in their top bit.

A run-time polarity bit selects how the most significant fraction bit is read. In the modern convention that bit is set in quiet NaNs. In the legacy convention the same bit marks a signaling NaN. The polarity also decides what quieting does. In the modern convention quieting sets the marker bit and keeps the sign and payload. In the legacy convention it replaces the whole word with the default NaN.

There is no clock and no state. A floating-point datapath places the unit next to its operand or result path and reads all four outputs in the same cycle as the word.

Top module: `nanq_top`

## Requirements
- R1: `fmt_sel` encodes the format: 0 is half in bits 15:0, 1 is single in bits 31:0, and 2 or 3 is double in bits 63:0. Input bits above the selected width have no effect, and the result outputs are zero above that width.
- R2: With `legacy_mode`=0, a word whose exponent is all ones and whose fraction MSB is 1 reports `is_qnan`=1 and `is_snan`=0.
- R3: With `legacy_mode`=0, a word whose exponent is all ones, whose fraction MSB is 0 and whose remaining fraction bits are nonzero reports `is_snan`=1 and `is_qnan`=0.
- R4: With `legacy_mode`=1, the two tests are swapped. A NaN with fraction MSB 1 is signaling, and a NaN with fraction MSB 0 and a nonzero rest is quiet.
- R5: Finite values and infinities (exponent all ones, fraction zero) report neither flag in either mode, and the two flags are never 1 together.
- R6: `default_nan` has sign 0 and an all-ones exponent. With `legacy_mode`=0 only the fraction MSB is set (single: 0x7FC00000). With `legacy_mode`=1 every fraction bit except the MSB is set (single: 0x7FBFFFFF).
- R7: With `legacy_mode`=0, the quieted word for a signaling NaN is the input with the fraction MSB set; sign and the other payload bits are kept.
- R8: With `legacy_mode`=1, the quieted word for a signaling NaN equals `default_nan`.
- R9: For every input that is not a signaling NaN, including quiet NaNs, the quieted word equals the input word within the selected width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fmt_sel | input | 2 | Format select: 0 half, 1 single, 2 or 3 double |
| legacy_mode | input | 1 | 0: fraction MSB set means quiet; 1: fraction MSB set means signaling |
| word_in | input | 64 | Operand, right-aligned for narrower formats |
| is_qnan | output | 1 | Operand is a quiet NaN |
| is_snan | output | 1 | Operand is a signaling NaN |
| quieted_word | output | 64 | Operand with any signaling NaN made quiet, zero-extended |
| default_nan | output | 64 | Default NaN for the format and mode, zero-extended |

## Verification
Classification and quieting act on the same word in the same evaluation. A wrong polarity or a mixed-up field position would show up in both outputs at once. The bench sweeps every 16-bit half-precision pattern in both modes, with random junk in the upper input bits. For each word it compares both flags, the quieted word and the default NaN against values computed arithmetically from magnitude thresholds. Single and double precision are covered by pseudo-random payloads at the all-ones exponent plus finite and infinite values, and format code 3 is checked against the double-precision expectation.

// File: rtl/nanq_pkg.sv
package nanq_pkg;

  localparam int WORD_W = 64;
  localparam int LANES  = 3;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    FMT_HALF   = 2'd0,
    FMT_SINGLE = 2'd1,
    FMT_DOUBLE = 2'd2,
    FMT_WIDE   = 2'd3
  } fmt_e;

  function automatic int lane_exp_w(input int idx);
    case (idx)
      0:       return 5;
      1:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int lane_frac_w(input int idx);
    case (idx)
      0:       return 10;
      1:       return 23;
      default: return 52;
    endcase
  endfunction

  function automatic logic [SEL_W-1:0] lane_of(input fmt_e f);
    return (f == FMT_WIDE) ? 2'd2 : f;
  endfunction

endpackage

// File: rtl/nanq_classify.sv
module nanq_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int MAG_W = EXP_W + FRAC_W
) (
  input  logic             legacy_mode,
  input  logic [MAG_W-1:0] mag,
  output logic             is_q,
  output logic             is_s
);

  logic exp_ones;
  logic frac_nz;
  logic marker;
  logic quiet_pol;
  logic nan;

  assign exp_ones  = &mag[MAG_W-1:FRAC_W];
  assign frac_nz   = |mag[FRAC_W-1:0];
  assign marker    = mag[FRAC_W-1];
  assign nan       = exp_ones & frac_nz;
  assign quiet_pol = marker ^ legacy_mode;
  assign is_q      = nan & quiet_pol;
  assign is_s      = nan & ~quiet_pol;

  always_comb begin
    assert_flags_exclusive_R5: assert (!(is_q && is_s));
    if (exp_ones && !frac_nz) begin
      assert_inf_no_flag_R5: assert (!is_q && !is_s);
    end
    if (is_q) begin
      assert_quiet_polarity_R4: assert (mag[FRAC_W-1] == !legacy_mode);
    end
  end

endmodule

// File: rtl/nanq_default.sv
module nanq_default #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int LW    = 1 + EXP_W + FRAC_W
) (
  input  logic          legacy_mode,
  output logic [LW-1:0] dflt
);

  assign dflt = {1'b0, {EXP_W{1'b1}}, ~legacy_mode, {(FRAC_W-1){legacy_mode}}};

endmodule

// File: rtl/nanq_quiet.sv
module nanq_quiet #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int LW    = 1 + EXP_W + FRAC_W
) (
  input  logic          legacy_mode,
  input  logic [LW-1:0] word,
  input  logic          is_s,
  input  logic [LW-1:0] dflt,
  output logic [LW-1:0] quiet
);

  always_comb begin
    quiet = word;
    if (is_s) begin
      if (legacy_mode) quiet = dflt;
      else             quiet = {word[LW-1:FRAC_W], 1'b1, word[FRAC_W-2:0]};
    end
  end

  always_comb begin
    if (!legacy_mode && is_s) begin
      assert_marker_set_R7: assert (quiet[FRAC_W-1] && (quiet[LW-1:FRAC_W] == word[LW-1:FRAC_W])
                                    && (quiet[FRAC_W-2:0] == word[FRAC_W-2:0]));
    end
    if (legacy_mode && is_s) begin
      assert_legacy_default_R8: assert (quiet == dflt);
    end
    if (!is_s) begin
      assert_passthrough_R9: assert (quiet == word);
    end
  end

endmodule

// File: rtl/nanq_top.sv
module nanq_top
  import nanq_pkg::*;
(
  input  logic [1:0]  fmt_sel,
  input  logic        legacy_mode,
  input  logic [63:0] word_in,
  output logic        is_qnan,
  output logic        is_snan,
  output logic [63:0] quieted_word,
  output logic [63:0] default_nan
);

  logic [LANES-1:0]  lane_q;
  logic [LANES-1:0]  lane_s;
  logic [WORD_W-1:0] lane_quiet [LANES];
  logic [WORD_W-1:0] lane_dflt  [LANES];
  logic [SEL_W-1:0]  sel;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    localparam int EW = lane_exp_w(gi);
    localparam int FW = lane_frac_w(gi);
    localparam int LW = 1 + EW + FW;

    logic [LW-1:0] w;
    logic [LW-1:0] d;
    logic [LW-1:0] qw;

    assign w = word_in[LW-1:0];

    nanq_classify #(.EXP_W(EW), .FRAC_W(FW)) u_cls (
      .legacy_mode(legacy_mode),
      .mag        (w[LW-2:0]),
      .is_q       (lane_q[gi]),
      .is_s       (lane_s[gi])
    );

    nanq_default #(.EXP_W(EW), .FRAC_W(FW)) u_dflt (
      .legacy_mode(legacy_mode),
      .dflt       (d)
    );

    nanq_quiet #(.EXP_W(EW), .FRAC_W(FW)) u_quiet (
      .legacy_mode(legacy_mode),
      .word       (w),
      .is_s       (lane_s[gi]),
      .dflt       (d),
      .quiet      (qw)
    );

    if (LW < WORD_W) begin : g_pad
      assign lane_quiet[gi] = {{(WORD_W-LW){1'b0}}, qw};
      assign lane_dflt[gi]  = {{(WORD_W-LW){1'b0}}, d};
    end else begin : g_full
      assign lane_quiet[gi] = qw;
      assign lane_dflt[gi]  = d;
    end
  end

  assign sel = lane_of(fmt_e'(fmt_sel));

  always_comb begin
    is_qnan      = lane_q[sel];
    is_snan      = lane_s[sel];
    quieted_word = lane_quiet[sel];
    default_nan  = lane_dflt[sel];
  end

endmodule

// File: tb/test_nanq_top.sv
module test_nanq_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_sel = '0;
  logic        legacy_mode = 1'b0;
  logic [63:0] word_in = '0;
  logic        is_qnan;
  logic        is_snan;
  logic [63:0] quieted_word;
  logic [63:0] default_nan;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  nanq_top i_nanq_top (
    .fmt_sel     (fmt_sel),
    .legacy_mode (legacy_mode),
    .word_in     (word_in),
    .is_qnan     (is_qnan),
    .is_snan     (is_snan),
    .quieted_word(quieted_word),
    .default_nan (default_nan)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= WATCHDOG_CYCLES && !done) begin
      n_checks = n_checks + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  function automatic logic [63:0] next_rng(input logic [63:0] s);
    logic [63:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_vec(input int fmt, input bit mode, input logic [63:0] w, input bit tag_r1);
    int e, f, lw;
    logic [63:0] mask, m, mag, inf, half, dflt, quiet;
    bit nan, hi, exq, exs;
    string tf, tq, td;
    fmt_sel = 2'(fmt);
    legacy_mode = mode;
    word_in = w;
    #1;
    e  = (fmt == 0) ? 5 : (fmt == 1) ? 8 : 11;
    f  = (fmt == 0) ? 10 : (fmt == 1) ? 23 : 52;
    lw = 1 + e + f;
    mask = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
    m    = w & mask;
    mag  = m & ~(64'd1 << (lw - 1));
    inf  = ((64'd1 << e) - 64'd1) << f;
    half = 64'd1 << (f - 1);
    nan  = mag > inf;
    hi   = mag >= (inf | half);
    exq  = nan && (mode ? !hi : hi);
    exs  = nan && (mode ? hi : !hi);
    dflt = mode ? (inf | (half - 64'd1)) : (inf | half);
    quiet = exs ? (mode ? dflt : (m | half)) : m;
    tf = !nan ? "R5" : mode ? "R4" : exs ? "R3" : "R2";
    tq = exs ? (mode ? "R8" : "R7") : "R9";
    td = "R6";
    if (tag_r1) begin tf = "R1"; tq = "R1"; td = "R1"; end
    chk(tf, "is_qnan", {63'd0, is_qnan}, {63'd0, exq});
    chk(tf, "is_snan", {63'd0, is_snan}, {63'd0, exs});
    chk(tq, "quieted_word", quieted_word, quiet);
    chk(td, "default_nan", default_nan, dflt);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle state: zero word, modern mode, half precision (R5, R6)
    #1;
    chk("R5", "idle is_qnan", {63'd0, is_qnan}, 64'd0);
    chk("R5", "idle is_snan", {63'd0, is_snan}, 64'd0);
    chk("R6", "idle default_nan", default_nan, 64'h7E00);

    // Exhaustive half precision in both modes, junk above bit 15 (R1..R9)
    for (int md = 0; md < 2; md++) begin
      for (int v = 0; v < 65536; v++) begin
        rng = next_rng(rng);
        run_vec(0, md[0], {rng[63:16], 16'(v)}, 1'b0);
      end
    end

    // Named corner values in single precision
    run_vec(1, 1'b0, 64'h7F80_0000, 1'b0); // +inf R5
    run_vec(1, 1'b1, 64'hFF80_0000, 1'b0); // -inf R5
    run_vec(1, 1'b0, 64'h7F80_0001, 1'b0); // sNaN modern R3/R7
    run_vec(1, 1'b1, 64'h7F80_0001, 1'b0); // qNaN legacy R4/R9
    run_vec(1, 1'b0, 64'hFFC0_1234, 1'b0); // qNaN modern R2
    run_vec(1, 1'b1, 64'hFFC0_1234, 1'b0); // sNaN legacy R8
    chk("R6", "single legacy default", default_nan, 64'h7FBF_FFFF);
    run_vec(1, 1'b0, 64'h3F80_0000, 1'b0);
    chk("R6", "single modern default", default_nan, 64'h7FC0_0000);

    // Single and double: random payloads at the all-ones exponent and elsewhere
    for (int fm = 1; fm < 3; fm++) begin
      for (int md = 0; md < 2; md++) begin
        for (int k = 0; k < 6000; k++) begin
          logic [63:0] w;
          rng = next_rng(rng);
          w = rng;
          if (k % 3 != 0) begin
            if (fm == 1) w[30:23] = 8'hFF;
            else         w[62:52] = 11'h7FF;
          end
          if (k % 7 == 0) begin
            if (fm == 1) w[22:0] = 23'd0;
            else         w[51:0] = 52'd0;
          end
          if (k % 11 == 0) begin
            if (fm == 1) w[21:0] = 22'd0;
            else         w[50:0] = 51'd0;
          end
          run_vec(fm, md[0], w, 1'b0);
        end
      end
    end

    // Format code 3 behaves as double precision (R1)
    for (int md = 0; md < 2; md++) begin
      for (int k = 0; k < 2000; k++) begin
        logic [63:0] w;
        rng = next_rng(rng);
        w = rng;
        if (k % 2 == 0) w[62:52] = 11'h7FF;
        run_vec(3, md[0], w, 1'b1);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule